// File: doc/BRIEF.md
# Timekeeping Divider and Rate Selector

This block is the timebase of a real-time clock. A single-cycle enable at 32.768 kHz advances a 15-stage binary divider. A 4-bit rate code picks one divider stage. That stage drives a gated square-wave output and a one-cycle periodic event, raised each time the chosen stage goes from 0 to 1. The same divider produces the once-per-second update strobe that the calendar logic uses to advance its counters. It also produces a busy flag that warns software that a transfer is about to happen.

A 3-bit control field sets the state of the divider. One pattern lets it count. Two patterns clear it and hold it at zero. Every other pattern stops it where it stands. While the freeze input (the SET bit) is high, the update strobe and the busy flag are suppressed, but the divider keeps counting. Every output changes only on the system clock.

Top module: `rtc_divider_rate`

## Requirements
- R1: Rate code 0 keeps the square wave low and produces no periodic event.
- R2: Rate codes 3 to 15 select a frequency of 32768 >> (code-1) Hz, from 8192 Hz down to 2 Hz. The square wave is high for the upper half of each period, counted from the divider reaching a multiple of the period.
- R3: Rate codes 1 and 2 select 256 Hz and 128 Hz, the same frequencies as codes 8 and 9.
- R4: When sqw_en is 0, sqw_out is held low whatever the rate code.
- R5: periodic_pulse is high for one cycle, one clock after each enabled tick that takes the selected stage from 0 to 1. This gives one event per period, and it does not depend on sqw_en.
- R6: Control field value 3'b010 lets the divider advance on each tick. Values 3'b110 and 3'b111 clear the divider to zero and hold it there. Every other value stops the divider, so no events and no updates occur.
- R7: After the divider is cleared and then released with 3'b010, the first update_tick follows the 16384th tick (500 ms). Later update strobes come every 32768 ticks.
- R8: update_busy is high while the divider is running and holds a count from 16376 to 16383, which is the 8 ticks (about 244 µs) before the update. It goes low in the same cycle that update_tick is high.
- R9: While set_hold is 1, update_busy stays low and no update_tick is produced, but the divider keeps counting.
- R10: Reset (rst_n low) clears the divider and both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| rate_code | input | 4 | Stage select for the square wave and the periodic event |
| div_ctl | input | 3 | Divider control: run, clear-and-hold or stop |
| sqw_en | input | 1 | Square-wave output enable |
| set_hold | input | 1 | Freeze: blocks the update strobe and the busy flag |
| sqw_out | output | 1 | Square wave from the selected stage |
| periodic_pulse | output | 1 | One-cycle strobe on each rising edge of the selected stage |
| update_tick | output | 1 | One-cycle once-per-second update strobe |
| update_busy | output | 1 | High during the 8 ticks before an update |

## Verification
The divider count changes at the clock edge on which a tick is taken. The square wave and the busy flag are decoded directly from that count, so both are due in the cycle after that edge. The periodic event and the update strobe are registered from the same edge and are due in that same following cycle. The bench model advances its own count at each rising edge and compares all four outputs once per cycle, one nanosecond after the falling edge, so every expected value has settled. Tick counts measured from release give the exact 16384-tick first update and the 32768-tick spacing.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam int unsigned DIV_STAGES = 15;
  localparam int unsigned RATE_W     = 4;
  localparam int unsigned CTL_W      = 3;
  localparam int unsigned IDX_W      = 4;

  typedef enum logic [1:0] {
    CHAIN_RUN   = 2'd0,
    CHAIN_CLEAR = 2'd1,
    CHAIN_STOP  = 2'd2
  } chain_mode_e;

  // Divider control decode: one run pattern, 11x clears, rest stop.
  function automatic chain_mode_e decode_ctl(input logic [CTL_W-1:0] f);
    if (f == 3'b010)        return CHAIN_RUN;
    else if (f[2:1] == 2'b11) return CHAIN_CLEAR;
    else                    return CHAIN_STOP;
  endfunction

  // Stage index for a rate code; stage i toggles at 32768/2^(i+1) Hz.
  function automatic logic [IDX_W-1:0] tap_index(input logic [RATE_W-1:0] code);
    case (code)
      4'd0:    return 4'd0;
      4'd1:    return 4'd6;
      4'd2:    return 4'd7;
      default: return code - 4'd2;
    endcase
  endfunction

  function automatic logic code_active(input logic [RATE_W-1:0] code);
    return code != '0;
  endfunction
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt,
  output logic              step
);
  assign step = tick_en && (mode == CHAIN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (mode == CHAIN_CLEAR) cnt <= '0;
    else if (step)               cnt <= cnt + 1'b1;
  end

  assert_clear_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CHAIN_CLEAR) |=> (cnt == '0));

  assert_stop_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CHAIN_STOP) |=> $stable(cnt));
endmodule

// File: rtl/rtc_tap_select.sv
module rtc_tap_select
  import rtc_div_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] cnt,
  input  logic              step,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              sqw_en,
  output logic              sqw_out,
  output logic              periodic_pulse
);
  logic [STAGES-1:0] nxt;
  logic [STAGES-1:0] rise_vec;
  logic [IDX_W-1:0]  idx;
  logic              active;
  logic              tap_rise;

  assign nxt    = cnt + 1'b1;
  assign idx    = tap_index(rate_code);
  assign active = code_active(rate_code);

  // Per-stage 0->1 detection for the coming increment.
  for (genvar i = 0; i < STAGES; i++) begin : g_rise
    assign rise_vec[i] = !cnt[i] && nxt[i];
  end

  assign tap_rise = step && active && rise_vec[idx];
  assign sqw_out  = sqw_en && active && cnt[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) periodic_pulse <= 1'b0;
    else        periodic_pulse <= tap_rise;
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_pulse |=> !periodic_pulse);

  assert_code0_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> !periodic_pulse);

  assert_sqw_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_out);
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_div_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES,
  parameter int unsigned LEAD   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] cnt,
  input  logic              step,
  input  logic              running,
  input  logic              set_hold,
  output logic              update_tick,
  output logic              update_busy
);
  localparam logic [STAGES-1:0] UPD_AT     = STAGES'(1) << (STAGES - 1);
  localparam logic [STAGES-1:0] UPD_LAST   = UPD_AT - 1'b1;
  localparam logic [STAGES-1:0] LEAD_START = UPD_AT - STAGES'(LEAD);

  logic fire;

  assign fire        = step && !set_hold && (cnt == UPD_LAST);
  assign update_busy = running && !set_hold && (cnt >= LEAD_START) && (cnt < UPD_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) update_tick <= 1'b0;
    else        update_tick <= fire;
  end

  assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    update_tick |-> !update_busy);

  assert_busy_before_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(update_tick) |-> $past(update_busy));

  assert_set_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_hold |=> !update_tick);
endmodule

// File: rtl/rtc_divider_rate.sv
module rtc_divider_rate
  import rtc_div_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES,
  parameter int unsigned LEAD   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [3:0] rate_code,
  input  logic [2:0] div_ctl,
  input  logic       sqw_en,
  input  logic       set_hold,
  output logic       sqw_out,
  output logic       periodic_pulse,
  output logic       update_tick,
  output logic       update_busy
);
  chain_mode_e       mode;
  logic [STAGES-1:0] cnt;
  logic              step;
  logic              running;

  assign mode    = decode_ctl(div_ctl);
  assign running = (mode == CHAIN_RUN);

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_32k), .mode(mode),
    .cnt(cnt), .step(step)
  );

  rtc_tap_select #(.STAGES(STAGES)) u_tap (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .step(step),
    .rate_code(rate_code), .sqw_en(sqw_en),
    .sqw_out(sqw_out), .periodic_pulse(periodic_pulse)
  );

  rtc_update_seq #(.STAGES(STAGES), .LEAD(LEAD)) u_upd (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .step(step), .running(running),
    .set_hold(set_hold), .update_tick(update_tick), .update_busy(update_busy)
  );

  assert_stopped_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!periodic_pulse && !update_tick));
endmodule

// File: tb/rtc_divider_rate_test.sv
module rtc_divider_rate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [2:0] div_ctl = 3'b110;
  logic       sqw_en = 1'b0;
  logic       set_hold = 1'b0;
  logic       sqw_out, periodic_pulse, update_tick, update_busy;

  int checks = 0;
  int failures = 0;
  int tick_every = 1;
  int tick_phase = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_divider_rate uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
    .div_ctl(div_ctl), .sqw_en(sqw_en), .set_hold(set_hold),
    .sqw_out(sqw_out), .periodic_pulse(periodic_pulse),
    .update_tick(update_tick), .update_busy(update_busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Frequency in Hz for each rate code, as listed in the requirements.
  function automatic int freq_hz(input logic [3:0] c);
    case (c)
      4'd1: return 256;   4'd2: return 128;   4'd3: return 8192;
      4'd4: return 4096;  4'd5: return 2048;  4'd6: return 1024;
      4'd7: return 512;   4'd8: return 256;   4'd9: return 128;
      4'd10: return 64;   4'd11: return 32;   4'd12: return 16;
      4'd13: return 8;    4'd14: return 4;    4'd15: return 2;
      default: return 0;
    endcase
  endfunction

  // Tick generator
  always @(negedge clk) begin
    tick_phase = (tick_phase + 1) % tick_every;
    tick_32k <= (tick_phase == 0);
  end

  // Behavioural reference, advanced at each rising edge.
  int  m_cnt = 0;
  bit  e_pulse = 0, e_upd = 0;
  longint run_ticks = 0;
  always @(posedge clk) begin
    e_pulse = 0; e_upd = 0;
    if (!rst_n) begin
      m_cnt = 0; run_ticks = 0;
    end else if (div_ctl == 3'b110 || div_ctl == 3'b111) begin
      m_cnt = 0; run_ticks = 0;
    end else if (div_ctl == 3'b010 && tick_32k) begin
      m_cnt = (m_cnt + 1) % 32768;
      run_ticks++;
      if (rate_code != 0) begin
        int p;
        p = 32768 / freq_hz(rate_code);
        if (m_cnt % p == p / 2) e_pulse = 1;
      end
      if (!set_hold && m_cnt == 16384) e_upd = 1;
    end
  end

  // Per-cycle comparison, mid-cycle after the falling edge.
  int     pulse_seen = 0, upd_seen = 0, busy_seen = 0;
  longint prev_upd = 0;
  bit     have_prev = 0;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit e_sqw, e_busy;
      e_sqw = 0;
      if (sqw_en && rate_code != 0) begin
        int h;
        h = 16384 / freq_hz(rate_code);
        e_sqw = ((m_cnt / h) % 2) == 1;
      end
      e_busy = (div_ctl == 3'b010) && !set_hold && m_cnt >= 16376 && m_cnt <= 16383;
      chk(sqw_out == e_sqw, "R2", "sqw_out", sqw_out, e_sqw);
      chk(periodic_pulse == e_pulse, "R5", "periodic_pulse", periodic_pulse, e_pulse);
      chk(update_tick == e_upd, "R7", "update_tick", update_tick, e_upd);
      chk(update_busy == e_busy, "R8", "update_busy", update_busy, e_busy);
      if (periodic_pulse) pulse_seen++;
      if (update_busy) busy_seen++;
      if (update_tick) begin
        upd_seen++;
        if (!have_prev)
          chk(run_ticks == 16384, "R7", "ticks to first update", run_ticks, 16384);
        else
          chk((run_ticks - prev_upd) % 32768 == 0 && run_ticks > prev_upd, "R7",
              "update spacing", run_ticks - prev_upd, 32768);
        prev_upd = run_ticks;
        have_prev = 1;
      end
      if (div_ctl == 3'b110 || div_ctl == 3'b111) have_prev = 0;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(4);
    // R10: reset state
    chk(!periodic_pulse && !update_tick && !update_busy && !sqw_out, "R10",
        "outputs in reset", {periodic_pulse, update_tick, update_busy, sqw_out}, 0);
    @(negedge clk); rst_n = 1'b1;
    rate_code = 4'd3; sqw_en = 1'b1; div_ctl = 3'b110;
    cycles(5);
    div_ctl = 3'b010;
    // First update then sweep all rate codes and sqw_en through the next one.
    cycles(16400);
    chk(upd_seen == 1, "R7", "first update count", upd_seen, 1);
    for (int k = 0; k < 32; k++) begin
      rate_code = 4'(k % 16);
      sqw_en = (k % 5) != 2;
      cycles(1030);
    end
    chk(upd_seen == 2, "R7", "second update count", upd_seen, 2);
    // R9: freeze over a whole second
    rate_code = 4'd15; sqw_en = 1'b1;
    set_hold = 1'b1; upd_seen = 0; busy_seen = 0;
    cycles(33000);
    chk(upd_seen == 0, "R9", "updates while frozen", upd_seen, 0);
    chk(busy_seen == 0, "R9", "busy while frozen", busy_seen, 0);
    set_hold = 1'b0;
    // R1: code 0 silent
    rate_code = 4'd0; pulse_seen = 0;
    cycles(1280);
    chk(pulse_seen == 0, "R1", "events with code 0", pulse_seen, 0);
    // R3: code 1 gives 128-tick period
    rate_code = 4'd1; pulse_seen = 0;
    cycles(1280);
    chk(pulse_seen == 10, "R3", "events with code 1", pulse_seen, 10);
    rate_code = 4'd2; pulse_seen = 0;
    cycles(1280);
    chk(pulse_seen == 5, "R3", "events with code 2", pulse_seen, 5);
    // R4: sqw gated
    rate_code = 4'd3; sqw_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      chk(sqw_out == 1'b0, "R4", "sqw_out disabled", sqw_out, 0);
    end
    sqw_en = 1'b1;
    // R6: stop patterns freeze the divider
    foreach (div_ctl[b]) ;
    div_ctl = 3'b000; pulse_seen = 0;
    cycles(600);
    div_ctl = 3'b101;
    cycles(600);
    chk(pulse_seen == 0, "R6", "events while stopped", pulse_seen, 0);
    div_ctl = 3'b010;
    // Sparse ticks
    tick_every = 2;
    rate_code = 4'd4;
    cycles(12000);
    tick_every = 1;
    // R6/R7: clear and restart, first update at 500 ms again
    div_ctl = 3'b111;
    cycles(10);
    upd_seen = 0;
    div_ctl = 3'b010;
    cycles(16400);
    chk(upd_seen == 1, "R6", "update after clear/restart", upd_seen, 1);
    cycles(4);
    finish_run();
  end
endmodule